// File: doc/BRIEF.md
# Fractional-Step PWM Generator with Boundary-Aligned Update

This block produces one pulse-width-modulated output. It holds a 16-bit phase accumulator that adds a programmable step on every clock and wraps modulo 65536. Each wrap starts a new PWM period, so the output frequency is the clock frequency times step / 65536. The output level comes from comparing the top eight accumulator bits against an 8-bit threshold. A larger threshold gives a shorter high time. A threshold T gives a high fraction of (256 - T) / 256.

Software drives the block through one 32-bit control word, written with a write strobe and read back continuously. New step and threshold values are first held in staging fields. They reach the running generator only when software sets the update-request bit. While the generator runs, the load waits for the next period boundary, so a period is never cut short or stretched by a reconfiguration. While the generator is stopped, the load happens at once. The request bit reads back as 1 until the load has happened.

Top module: `frac_pwm`

## Requirements
- R1: After reset, rd_data reads 0 and pwm_out is low.
- R2: A write stores bit 31 (run enable), bits 23:8 (staged step) and bits 7:0 (staged threshold). These read back unchanged, and bits 29:24 read 0. A read-modify-write that changes only the step or threshold therefore keeps the enable as it was.
- R3: While run enable reads 0, pwm_out is low and the accumulator is held at 0. The staged fields are kept.
- R4: While enabled, the accumulator adds the active step on every clock, modulo 65536. With step 256 the period is 256 clocks.
- R5: While enabled, pwm_out is high exactly when accumulator bits 15:8 are greater than or equal to the active threshold. Threshold 64 at step 256 gives 192 high clocks in every 256.
- R6: A write with bit 30 set while enabled makes bit 30 read 1. The active values change only on the clock after an accumulator wrap, and bit 30 then reads 0.
- R7: A write with bit 30 clear changes only the staged fields. The running output is unchanged.
- R8: A write with bit 30 set while disabled loads the new step and threshold at once and leaves bit 30 at 0. A request still pending when the block becomes disabled is loaded on the next clock.
- R9: An active step of 0 freezes the accumulator, so the output holds a constant level and a pending request stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the accumulator advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word: enable, pending flag, staged step, staged threshold |
| pwm_out | output | 1 | PWM output |

## Verification
A fault in the accumulator or the active step shows up at pwm_out as a shifted edge within one period, and as a wrong high count over any full-period window. A fault in the pending flag or the load condition shows in bit 30 of rd_data, either at once or at the first wrap. It also shows as a threshold change that arrives too early or never arrives. The bench keeps a cycle-accurate reference that predicts both outputs on every clock, so a divergence is reported in the cycle it first reaches a port. High-count and edge-count windows then tie each result to a specific requirement.

// File: rtl/frac_pwm_pkg.sv
package frac_pwm_pkg;

    localparam int unsigned CTRL_W   = 32;
    localparam int unsigned ACC_W    = 16;
    localparam int unsigned DUTY_W   = 8;
    localparam int unsigned EN_BIT   = 31;
    localparam int unsigned UPD_BIT  = 30;
    localparam int unsigned STEP_LSB = 8;
    localparam int unsigned DUTY_LSB = 0;
    localparam int unsigned STEP_MSB = STEP_LSB + ACC_W - 1;
    localparam int unsigned DUTY_MSB = DUTY_LSB + DUTY_W - 1;

    typedef logic [ACC_W-1:0]  step_t;
    typedef logic [DUTY_W-1:0] duty_t;

    typedef struct packed {
        logic  run;
        logic  pend;
        step_t stg_step;
        duty_t stg_duty;
        step_t act_step;
        duty_t act_duty;
    } ctl_state_t;

    typedef struct packed {
        step_t phase;
    } acc_state_t;

    function automatic step_t field_step(input logic [CTRL_W-1:0] w);
        return w[STEP_MSB:STEP_LSB];
    endfunction

    function automatic duty_t field_duty(input logic [CTRL_W-1:0] w);
        return w[DUTY_MSB:DUTY_LSB];
    endfunction

endpackage

// File: rtl/frac_pwm_ctl.sv
module frac_pwm_ctl
    import frac_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              wrap,
    output logic              run_q,
    output logic              pend_q,
    output step_t             stg_step_q,
    output duty_t             stg_duty_q,
    output step_t             act_step_q,
    output duty_t             act_duty_q
);

    ctl_state_t st_d, st_q;
    logic       wr_upd;
    logic       direct_ld;
    logic       boundary_ld;

    always_comb begin
        st_d        = st_q;
        wr_upd      = wr_en & wr_data[UPD_BIT];
        direct_ld   = wr_upd & ~st_q.run;
        boundary_ld = st_q.pend & (wrap | ~st_q.run);

        if (wr_en) begin
            st_d.run      = wr_data[EN_BIT];
            st_d.stg_step = field_step(wr_data);
            st_d.stg_duty = field_duty(wr_data);
        end

        if (direct_ld) begin
            st_d.act_step = field_step(wr_data);
            st_d.act_duty = field_duty(wr_data);
        end else if (boundary_ld) begin
            st_d.act_step = st_q.stg_step;
            st_d.act_duty = st_q.stg_duty;
        end

        if (direct_ld) begin
            st_d.pend = 1'b0;
        end else begin
            st_d.pend = (st_q.pend & ~boundary_ld) | (wr_upd & st_q.run);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_q      = st_q.run;
    assign pend_q     = st_q.pend;
    assign stg_step_q = st_q.stg_step;
    assign stg_duty_q = st_q.stg_duty;
    assign act_step_q = st_q.act_step;
    assign act_duty_q = st_q.act_duty;

endmodule

// File: rtl/frac_pwm_accum.sv
module frac_pwm_accum
    import frac_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  step_t step,
    output step_t phase_q,
    output logic  wrap
);

    localparam int unsigned SUM_W = ACC_W + 1;

    acc_state_t       st_d, st_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.phase} + {1'b0, step};
        wrap = run & sum[ACC_W];
        if (run) begin
            st_d.phase = sum[ACC_W-1:0];
        end else begin
            st_d.phase = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_q = st_q.phase;

endmodule

// File: rtl/frac_pwm_cmp.sv
module frac_pwm_cmp
    import frac_pwm_pkg::*;
(
    input  logic  run,
    input  step_t phase,
    input  duty_t thresh,
    output logic  level
);

    localparam int unsigned TOP_LSB = ACC_W - DUTY_W;

    duty_t top_bits;

    always_comb begin
        top_bits = phase[ACC_W-1:TOP_LSB];
        level    = run & (top_bits >= thresh);
    end

endmodule

// File: rtl/frac_pwm.sv
module frac_pwm
    import frac_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              pwm_out
);

    logic  run_q;
    logic  pend_q;
    step_t stg_step_q;
    duty_t stg_duty_q;
    step_t act_step_q;
    duty_t act_duty_q;
    step_t phase_q;
    logic  wrap;

    frac_pwm_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wrap       (wrap),
        .run_q      (run_q),
        .pend_q     (pend_q),
        .stg_step_q (stg_step_q),
        .stg_duty_q (stg_duty_q),
        .act_step_q (act_step_q),
        .act_duty_q (act_duty_q)
    );

    frac_pwm_accum u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .step    (act_step_q),
        .phase_q (phase_q),
        .wrap    (wrap)
    );

    frac_pwm_cmp u_cmp (
        .run    (run_q),
        .phase  (phase_q),
        .thresh (act_duty_q),
        .level  (pwm_out)
    );

    always_comb begin
        rd_data                    = '0;
        rd_data[EN_BIT]            = run_q;
        rd_data[UPD_BIT]           = pend_q;
        rd_data[STEP_MSB:STEP_LSB] = stg_step_q;
        rd_data[DUTY_MSB:DUTY_LSB] = stg_duty_q;
    end

endmodule

// File: rtl/frac_pwm_chk.sv
module frac_pwm_chk
    import frac_pwm_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  run_q,
    input logic  pend_q,
    input step_t phase_q,
    input step_t act_step_q,
    input duty_t act_duty_q,
    input logic  wrap,
    input logic  pwm_out
);

    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !pwm_out); // R3

    AST_STOPPED_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (phase_q == '0)); // R3

    AST_PHASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |-> (phase_q == step_t'($past(phase_q) + $past(act_step_q)))); // R4

    AST_ZERO_THRESH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && act_duty_q == '0) |-> pwm_out); // R5

    AST_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_q) && ((act_step_q != $past(act_step_q)) || (act_duty_q != $past(act_duty_q))))
        |-> ($past(wrap) && $past(pend_q))); // R6

    AST_ZERO_STEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && act_step_q == '0) |=> (!run_q || $stable(phase_q))); // R9

endmodule

bind frac_pwm frac_pwm_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_q      (run_q),
    .pend_q     (pend_q),
    .phase_q    (phase_q),
    .act_step_q (act_step_q),
    .act_duty_q (act_duty_q),
    .wrap       (wrap),
    .pwm_out    (pwm_out)
);

// File: tb/frac_pwm_bench.sv
module frac_pwm_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    typedef struct {
        logic        pwm;
        logic [31:0] rd;
    } exp_t;
    exp_t sb[$];

    logic        m_en, m_pend;
    logic [15:0] m_ss, m_as, m_acc;
    logic [7:0]  m_sd, m_ad;

    frac_pwm u_frac_pwm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: predicts the state after each edge and pushes it
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_pend = 0; m_ss = 0; m_sd = 0; m_as = 0; m_ad = 0; m_acc = 0;
        end else begin
            logic        carry, load, direct, wupd;
            logic [16:0] s;
            exp_t        e;
            s      = {1'b0, m_acc} + {1'b0, m_as};
            carry  = m_en && s[16];
            load   = m_pend && (carry || !m_en);
            wupd   = wr_en && wr_data[30];
            direct = wupd && !m_en;
            if (direct) begin
                m_as = wr_data[23:8]; m_ad = wr_data[7:0];
            end else if (load) begin
                m_as = m_ss; m_ad = m_sd;
            end
            m_pend = direct ? 1'b0 : ((m_pend && !load) || (wupd && m_en));
            m_acc  = m_en ? s[15:0] : 16'd0;
            if (wr_en) begin
                m_en = wr_data[31]; m_ss = wr_data[23:8]; m_sd = wr_data[7:0];
            end
            e.pwm = m_en && (m_acc[15:8] >= m_ad);
            e.rd  = {m_en, m_pend, 6'd0, m_ss, m_sd};
            sb.push_back(e);
        end
    end

    // Monitor: compares outputs away from the active edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk({cur_req, " pwm_out"}, {31'd0, pwm_out}, {31'd0, e.pwm});
            chk({cur_req, " rd_data"}, rd_data, e.rd);
        end
    end

    task automatic wr(input bit en, input bit upd, input logic [15:0] step, input logic [7:0] duty);
        wr_en   = 1'b1;
        wr_data = {en, upd, 6'd0, step, duty};
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic count_window(input int n, output int highs, output int rises);
        logic prev;
        highs = 0; rises = 0; prev = pwm_out;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) highs++;
            if (pwm_out && !prev) rises++;
            prev = pwm_out;
            @(negedge clk);
        end
    endtask

    task automatic wait_clear(input int limit);
        for (int i = 0; i < limit; i++) begin
            if (!rd_data[30]) break;
            @(negedge clk);
        end
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        int h, r;
        repeat (3) @(negedge clk);
        chk("R1 reset rd_data", rd_data, 32'd0);
        chk("R1 reset pwm_out", {31'd0, pwm_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: load at once while stopped; R4/R5 at step 256, threshold 64
        cur_req = "R8";
        wr(1, 1, 16'd256, 8'd64);
        chk("R8 no pending after direct load", {31'd0, rd_data[30]}, 32'd0);
        cur_req = "R5";
        count_window(256, h, r);
        chk("R5 high clocks per 256", h, 192);
        cur_req = "R4";
        count_window(512, h, r);
        chk("R4 rises in 512 clocks", r, 2);

        // R7: staged-only write leaves the running output alone
        cur_req = "R7";
        wr(1, 0, 16'd1024, 8'd200);
        chk("R2 readback of staged fields", rd_data, {1'b1, 1'b0, 6'd0, 16'd1024, 8'd200});
        count_window(256, h, r);
        chk("R7 high clocks unchanged", h, 192);

        // R6: deferred load at the next wrap
        cur_req = "R6";
        wr(1, 1, 16'd1024, 8'd192);
        chk("R6 pending reads 1", {31'd0, rd_data[30]}, 32'd1);
        wait_clear(400);
        chk("R6 pending cleared", {31'd0, rd_data[30]}, 32'd0);
        count_window(256, h, r);
        chk("R6 high clocks after load", h, 64);

        // R3: stopping holds output low and keeps staged fields
        cur_req = "R3";
        wr(0, 0, 16'd1024, 8'd192);
        count_window(20, h, r);
        chk("R3 low while stopped", h, 0);
        chk("R3 staged kept", rd_data, {1'b0, 1'b0, 6'd0, 16'd1024, 8'd192});

        // R9: zero step freezes the level and a request stays pending
        cur_req = "R9";
        wr(1, 1, 16'd0, 8'd0);
        wr(1, 1, 16'd256, 8'd10);
        count_window(300, h, r);
        chk("R9 constant high level", h, 300);
        chk("R9 request still pending", {31'd0, rd_data[30]}, 32'd1);

        // R8: pending request loads on stop; R2 enable read-back
        cur_req = "R8";
        wr(0, 1, 16'd256, 8'd10);
        @(negedge clk);
        chk("R8 pending loaded while stopped", {31'd0, rd_data[30]}, 32'd0);
        cur_req = "R2";
        wr(1, 0, 16'd256, 8'd10);
        chk("R2 enable reads back", {31'd0, rd_data[31]}, 32'd1);
        cur_req = "R8";
        count_window(256, h, r);
        chk("R8 high clocks with loaded threshold 10", h, 246);

        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

endmodule